// File: doc/BRIEF.md
# Parallel Position Feedback Converter

This block turns raw parallel position feedback into a signed 48-bit fixed-point position word whose low five bits are the fractional part. On a start strobe it decodes a 4-bit conversion code and a small set of control bits. It then fetches its source data through a simple register-read port and writes the converted value to a result register, which it flags with a one-cycle valid pulse.

The source can take one of two shapes. The first is a single 24-bit word read from the base address. The second is a 24-bit value packed from three consecutive registers, where the same byte lane is taken from each register. The packed value is sign-extended to 48 bits. It is then aligned in one of three ways: moved up by five bits, so that one source LSB is one whole count; moved down by three bits, for 16-bit data that sits in the top of the word; or left unmoved, for data that already carries five fraction bits. Two codes add the aligned value to the result of the previous conversion instead of replacing it.

Reserved codes raise an error pulse instead of a conversion, and so do codes that disagree with the control bits. In either case no read is issued and the stored result is not touched.

Top module: `ppos_converter`

## Requirements
- R1: After reset, `res_value` is 0, and `res_valid`, `res_err` and `rd_req` are all 0.
- R2: The control bits select a single-word read when `cfg_narrow` is 0, or when `cfg_narrow` is 1 and `cfg_lane` is 0. A valid single-word conversion issues exactly one read, at `cfg_base`.
- R3: Codes 4'h0 and 4'h1 sign-extend the source from 24 to 48 bits and shift it left by 5, so that source bit 0 lands in result bit 5.
- R4: Code 4'hC sign-extends a single word and shifts it right by 3 arithmetically, so that source bit 8 lands in result bit 5.
- R5: Codes 4'h8 and 4'h9 sign-extend the source without shifting it, so that source bit 0 lands in result bit 0.
- R6: Codes 4'h1 and 4'h9 add the aligned value to the current `res_value`, modulo 2^48. All other valid codes replace `res_value`.
- R7: Codes 4'h5/4'h6/4'h7 (left by 5) and 4'hD/4'hE/4'hF (no shift) select byte assembly. Byte assembly requires `cfg_narrow`=1 and `cfg_lane` equal to the code's low two bits, where lane 1 is bits 7:0, lane 2 is bits 15:8 and lane 3 is bits 23:16. Reads go to `cfg_base`, `cfg_base`+1 and `cfg_base`+2 (modulo 2^16), in that order. Their bytes fill bits 7:0, 15:8 and 23:16 of the 24-bit value, which is then sign-extended.
- R8: Codes 4'h2, 4'h3, 4'h4, 4'hA and 4'hB pulse `res_err` for one cycle, in the cycle after start. They issue no read, raise no `res_valid`, and leave `res_value` unchanged.
- R9: Three combinations are treated like reserved codes: a byte code with single-word control, a byte code whose lane differs from `cfg_lane`, and a single-word code (0, 1, 8, 9, C) with byte-assembly control.
- R10: Each completed conversion raises `res_valid` for exactly one cycle. `res_value` changes only in a cycle where `res_valid` is high.
- R11: A start strobe that arrives while a conversion is in progress is ignored.
- R12: `rd_req` stays high with `rd_addr` unchanged until `rd_ack` is seen. The source data is taken from `rd_data` in the cycle in which `rd_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| cfg_mode | input | 4 | Conversion code |
| cfg_narrow | input | 1 | Byte-assembly control enable |
| cfg_lane | input | 2 | Byte lane select (0 = single word) |
| cfg_base | input | 16 | Base source address |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_ack | input | 1 | Read response strobe |
| rd_data | input | 24 | Read response data |
| res_value | output | 48 | Converted position, 5 fraction bits |
| res_valid | output | 1 | One-cycle conversion-complete pulse |
| res_err | output | 1 | One-cycle rejected-configuration pulse |

## Verification
The assertions assume that the read port answers only an outstanding request. They also assume that `rd_ack` never arrives while `rd_req` is low, and that `rd_data` is meaningful in the acknowledge cycle. The bench's source model follows these rules: it acknowledges only a pending request, after a latency of 0 to 3 cycles that each vector chooses. Its data depends only on the requested address, so every expected value can be derived from the address sequence. Starts issued during a conversion come from the bench on purpose, to exercise R11, and they carry a different configuration so that any leak would show in the result.

// File: rtl/ppos_converter.sv
module ppos_converter #(
  parameter int ADDR_W = 16,
  parameter int SRC_W  = 24,
  parameter int RES_W  = 48,
  parameter int LSH    = 5,
  parameter int RSH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_narrow,
  input  logic [1:0]        cfg_lane,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [SRC_W-1:0]  rd_data,
  output logic [RES_W-1:0]  res_value,
  output logic              res_valid,
  output logic              res_err
);
  localparam int LANE_W = SRC_W / 3;

  typedef enum logic [1:0] {SH_LEFT, SH_NONE, SH_RIGHT} shift_t;

  logic   code_ok, code_byte, code_sum;
  shift_t code_shift;

  always_comb begin
    code_ok    = 1'b1;
    code_byte  = 1'b0;
    code_sum   = 1'b0;
    code_shift = SH_LEFT;
    case (cfg_mode)
      4'h0: ;
      4'h1: code_sum = 1'b1;
      4'h8: code_shift = SH_NONE;
      4'h9: begin code_shift = SH_NONE; code_sum = 1'b1; end
      4'hC: code_shift = SH_RIGHT;
      4'h5, 4'h6, 4'h7: code_byte = 1'b1;
      4'hD, 4'hE, 4'hF: begin code_byte = 1'b1; code_shift = SH_NONE; end
      default: code_ok = 1'b0;
    endcase
  end

  wire ctl_byte = cfg_narrow && (cfg_lane != 2'd0);
  wire cfg_good = code_ok && (code_byte == ctl_byte) &&
                  (!code_byte || cfg_lane == cfg_mode[1:0]);

  logic                busy;
  logic [1:0]          idx;
  logic [ADDR_W-1:0]   base_q;
  logic                byte_q, sum_q;
  logic [1:0]          lane_q;
  shift_t              shift_q;
  logic [2*LANE_W-1:0] lo_q;
  logic [RES_W-1:0]    res_q;
  logic                valid_q, err_q;

  assign rd_req    = busy;
  assign rd_addr   = base_q + ADDR_W'(idx);
  assign res_value = res_q;
  assign res_valid = valid_q;
  assign res_err   = err_q;

  logic [LANE_W-1:0] lane_byte;
  always_comb begin
    case (lane_q)
      2'd1:    lane_byte = rd_data[LANE_W-1:0];
      2'd2:    lane_byte = rd_data[2*LANE_W-1:LANE_W];
      default: lane_byte = rd_data[3*LANE_W-1:2*LANE_W];
    endcase
  end

  wire [SRC_W-1:0] src_word = byte_q ? SRC_W'({lane_byte, lo_q}) : rd_data;
  wire signed [RES_W-1:0] sx = {{(RES_W-SRC_W){src_word[SRC_W-1]}}, src_word};

  logic signed [RES_W-1:0] aligned;
  always_comb begin
    case (shift_q)
      SH_LEFT:  aligned = sx <<< LSH;
      SH_RIGHT: aligned = sx >>> RSH;
      default:  aligned = sx;
    endcase
  end

  wire [RES_W-1:0] next_res = sum_q ? res_q + aligned : aligned;
  wire last_read = !byte_q || idx == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      base_q  <= '0;
      byte_q  <= 1'b0;
      sum_q   <= 1'b0;
      lane_q  <= '0;
      shift_q <= SH_LEFT;
      lo_q    <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (cfg_good) begin
            busy    <= 1'b1;
            idx     <= '0;
            base_q  <= cfg_base;
            byte_q  <= code_byte;
            sum_q   <= code_sum;
            lane_q  <= cfg_lane;
            shift_q <= code_shift;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (rd_ack) begin
        if (last_read) begin
          res_q   <= next_res;
          valid_q <= 1'b1;
          busy    <= 1'b0;
        end else begin
          if (idx == 2'd0) lo_q[LANE_W-1:0] <= lane_byte;
          else             lo_q[2*LANE_W-1:LANE_W] <= lane_byte;
          idx <= idx + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ppos_converter_chk.sv
module ppos_converter_chk #(
  parameter int ADDR_W = 16,
  parameter int RES_W  = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic [RES_W-1:0]  res_value,
  input logic              res_valid,
  input logic              res_err
);
  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_err)); // R8
  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> !rd_req && $stable(res_value)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_value)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr)); // R12
  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (res_valid && !rd_req) ||
                           (rd_req && rd_addr == $past(rd_addr) + ADDR_W'(1))); // R7
endmodule

bind ppos_converter ppos_converter_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .res_value(res_value), .res_valid(res_valid), .res_err(res_err));

// File: tb/ppos_converter_test.sv
`timescale 1ns/1ps
module ppos_converter_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] cfg_mode = '0;
  logic cfg_narrow = 1'b0;
  logic [1:0] cfg_lane = '0;
  logic [15:0] cfg_base = '0;
  logic rd_req, rd_ack = 1'b0;
  logic [15:0] rd_addr;
  logic [23:0] rd_data = '0;
  logic [47:0] res_value;
  logic res_valid, res_err;

  always #4 clk = ~clk;

  ppos_converter uut (.*);

  int total = 0, fails = 0, cycles = 0;
  int lat = 0, wcnt = 0, nlog = 0;
  logic [15:0] log_addr [0:7];
  logic [47:0] exp_prev = '0;

  function automatic logic [23:0] src(input logic [15:0] a);
    return {a[7:0] ^ 8'h80, a[7:0] ^ 8'h3C, a[7:0] + 8'h01};
  endfunction

  always @(negedge clk) begin
    rd_ack = 1'b0;
    if (rd_req) begin
      if (wcnt >= lat) begin
        rd_ack = 1'b1;
        rd_data = src(rd_addr);
        if (nlog < 8) log_addr[nlog] = rd_addr;
        nlog++;
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] model(input logic [3:0] m, input logic byte_sel,
      input logic [1:0] ln, input logic [15:0] b, input logic [47:0] prev);
    logic [23:0] w;
    logic signed [47:0] s;
    if (byte_sel) begin
      for (int i = 0; i < 3; i++) begin
        logic [23:0] r;
        r = src(b + 16'(i));
        w[8*i +: 8] = r[8*(int'(ln)-1) +: 8];
      end
    end else w = src(b);
    s = {{24{w[23]}}, w};
    if (m == 4'hC) s = s >>> 3;
    else if (!m[3]) s = s <<< 5;
    return (m[2:0] == 3'd1) ? prev + s : s;
  endfunction

  // {mode, narrow, lane, base, expect_err, latency}
  localparam int NV = 24;
  localparam logic [25:0] VECS [0:NV-1] = '{
    {4'h0, 1'b0, 2'd0, 16'h0010, 1'b0, 2'd0},  // R3 negative word
    {4'h0, 1'b1, 2'd0, 16'h0090, 1'b0, 2'd0},  // R2 narrow with lane 0
    {4'h1, 1'b0, 2'd0, 16'h0090, 1'b0, 2'd1},  // R6
    {4'h8, 1'b0, 2'd0, 16'h0010, 1'b0, 2'd0},  // R5
    {4'h9, 1'b0, 2'd0, 16'h00F0, 1'b0, 2'd2},  // R6
    {4'hC, 1'b0, 2'd0, 16'h0010, 1'b0, 2'd0},  // R4 negative
    {4'hC, 1'b0, 2'd0, 16'h0090, 1'b0, 2'd3},  // R4 positive
    {4'h5, 1'b1, 2'd1, 16'h0020, 1'b0, 2'd0},  // R7
    {4'h6, 1'b1, 2'd2, 16'h0030, 1'b0, 2'd2},  // R7
    {4'h7, 1'b1, 2'd3, 16'h0010, 1'b0, 2'd0},  // R7 negative top
    {4'hD, 1'b1, 2'd1, 16'h00FE, 1'b0, 2'd0},  // R7
    {4'hE, 1'b1, 2'd2, 16'h0040, 1'b0, 2'd1},  // R7
    {4'hF, 1'b1, 2'd3, 16'h0085, 1'b0, 2'd1},  // R7 positive top
    {4'h2, 1'b0, 2'd0, 16'h0010, 1'b1, 2'd0},  // R8
    {4'h3, 1'b1, 2'd1, 16'h0010, 1'b1, 2'd0},  // R8
    {4'h4, 1'b0, 2'd0, 16'h0010, 1'b1, 2'd0},  // R8
    {4'hA, 1'b0, 2'd0, 16'h0010, 1'b1, 2'd0},  // R8
    {4'hB, 1'b1, 2'd3, 16'h0010, 1'b1, 2'd0},  // R8
    {4'h5, 1'b0, 2'd1, 16'h0010, 1'b1, 2'd0},  // R9 byte code, word control
    {4'h6, 1'b1, 2'd3, 16'h0010, 1'b1, 2'd0},  // R9 lane mismatch
    {4'h1, 1'b1, 2'd2, 16'h0010, 1'b1, 2'd0},  // R9 sum with bytes
    {4'hC, 1'b1, 2'd1, 16'h0010, 1'b1, 2'd0},  // R9 right shift with bytes
    {4'h9, 1'b0, 2'd0, 16'h0033, 1'b0, 2'd0},  // R6 after errors
    {4'hF, 1'b1, 2'd3, 16'hFFFF, 1'b0, 2'd0}   // R7 address wrap
  };

  task automatic run_vec(input logic [25:0] v);
    logic [3:0] m;
    logic nar, xerr, byte_sel, got_v, got_e;
    logic [1:0] ln;
    logic [15:0] b;
    logic [47:0] exp_val;
    string tag;
    int nexp;
    {m, nar, ln, b, xerr, lat} = {v[25:2], v[1:0]};
    m = v[25:22]; nar = v[21]; ln = v[20:19]; b = v[18:3]; xerr = v[2]; lat = int'(v[1:0]);
    byte_sel = nar && ln != 2'd0;
    if (xerr) tag = (m inside {4'h2, 4'h3, 4'h4, 4'hA, 4'hB}) ? "R8" : "R9";
    else if (byte_sel) tag = "R7";
    else if (m == 4'hC) tag = "R4";
    else if (m[2:0] == 3'd1) tag = "R6";
    else if (m == 4'h8) tag = "R5";
    else tag = "R3";
    exp_val = xerr ? exp_prev : model(m, byte_sel, ln, b, exp_prev);
    nexp = xerr ? 0 : (byte_sel ? 3 : 1);
    @(negedge clk);
    nlog = 0;
    cfg_mode = m; cfg_narrow = nar; cfg_lane = ln; cfg_base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_v = 1'b0; got_e = 1'b0;
    for (int t = 0; t < 40; t++) begin
      if (res_valid || res_err) begin got_v = res_valid; got_e = res_err; break; end
      @(negedge clk);
    end
    chk(got_e == xerr, tag, "error flag", 48'(got_e), 48'(xerr));
    chk(got_v == !xerr, tag, "valid flag", 48'(got_v), 48'(!xerr));
    chk(res_value == exp_val, tag, "result", res_value, exp_val);
    chk(nlog == nexp, byte_sel ? "R7" : "R2", "read count", 48'(nlog), 48'(nexp));
    for (int i = 0; i < nexp && i < nlog; i++)
      chk(log_addr[i] == b + 16'(i), byte_sel ? "R7" : "R2", "read address",
          48'(log_addr[i]), 48'(b + 16'(i)));
    @(negedge clk);
    chk(!res_valid && !res_err, "R10", "pulse width", 48'({res_valid, res_err}), 48'd0);
    if (!xerr) exp_prev = exp_val;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_value == 48'd0 && !res_valid && !res_err && !rd_req, "R1", "reset state",
        {res_value[44:0], res_valid, res_err, rd_req}, 48'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    begin : busy_start
      logic [47:0] e;
      int nv;
      lat = 3;
      e = model(4'h0, 1'b0, 2'd0, 16'h0010, exp_prev);
      @(negedge clk);
      nlog = 0;
      cfg_mode = 4'h0; cfg_narrow = 1'b0; cfg_lane = 2'd0; cfg_base = 16'h0010; start = 1'b1;
      @(negedge clk);
      cfg_mode = 4'h8; cfg_base = 16'h0050;
      repeat (2) @(negedge clk);
      start = 1'b0;
      nv = 0;
      for (int t = 0; t < 20; t++) begin
        if (res_valid) nv++;
        @(negedge clk);
      end
      chk(nv == 1, "R11", "valid count", 48'(nv), 48'd1);
      chk(res_value == e, "R11", "result from first config", res_value, e);
      chk(nlog == 1 && log_addr[0] == 16'h0010, "R11", "reads", 48'(log_addr[0]), 48'h10);
      exp_prev = e;
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule